// File: doc/BRIEF.md
# Ethernet MAC control registers and interrupt unit

This block is the software-visible control plane of a simple Ethernet MAC. It decodes a 32-bit register space on a 10-bit offset. It holds the event flags and their mask, the on/off and soft-reset control, and the transmit and receive control words. It also holds the station address, the FIFO start and watermark words, the two descriptor ring base addresses and the largest receive buffer size. Each writable register applies its own keep-mask and forced bits on write. Event flags are cleared by writing ones. The descriptor engines raise flags through a set vector.

Thirteen interrupt lines fan out from the events. Each line is the AND of one event flag and its mask bit. Writes to two trigger offsets produce single-cycle start pulses for the transmit and receive descriptor engines. Those engines report through two inputs whether a free receive descriptor is available. Register accesses are single-cycle. Read data is valid in the same cycle as the request, and there is no back-pressure. An access to an offset outside the map is answered with zero and is flagged.

Top module: `mac_csr_irq`

## Requirements
- R1: The event word reads its flags in bits 31:19. Writing to offset 0x004 clears every flag whose data bit is 1. A set pulse `evt_set[i]` sets flag bit 19+i one cycle later. A set and a clear on the same bit in one cycle leave the bit set.
- R2: Interrupt line k is the AND of one event flag and the mask bit at the same position. The lines 0 to 12 take, in order, bits 27, 26, 19, 20, 25, 24, 23, 21, 31, 28, 22, 29 and 30.
- R3: The mask word at offset 0x008 stores and reads back all 32 bits. After a write of zero, every interrupt line is low.
- R4: A write to the control word at 0x024 with bit 0 set restores the defaults, and the control word reads 0. The defaults clear the events, the mask, the speed word (0x044), the transmit control word (0x0C4) and the watermark (0x144). They set receive control (0x084) to 0x05EE0001 and the receive FIFO start (0x150) to 0x500. Ring bases keep their values.
- R5: Offset 0x010 reads the receive-active flag in bit 24. The flag is set by `rx_on_set` only while control bit 1 (enable) is 1. It is cleared by `rx_on_clr`, and by any control write that leaves enable at 0.
- R6: A write to 0x010 gives a one-cycle `rx_kick` on the next cycle, but only when enable is 1 and receive is not active.
- R7: A write to 0x014 gives a one-cycle `tx_kick` on the next cycle when enable is 1 and nothing when it is 0. Offset 0x014 reads 0.
- R8: Write masks are applied as follows:
  - The speed word keeps `value & 0xFE`.
  - Receive control keeps `value & 0x07FF003F`.
  - The watermark keeps bits 1:0.
  - The receive FIFO start stores `(value & 0x3FC) | 0x400`.
  - Both ring bases (0x180 receive, 0x184 transmit) clear bits 1:0.
  - The maximum buffer size (0x188) keeps `value & 0x7F0`.
- R9: A write to 0x0C4 with bit 0 set raises the graceful-stop flag (bit 28).
- R10: Offset 0x0E4 holds address bytes 0 to 3, byte 0 in bits 31:24. Offset 0x0E8 holds bytes 4 and 5 in bits 31:16 and reads 0x8808 in bits 15:0. `station_addr` presents byte 0 in bits 47:40. Offset 0x0EC reads 0x10000 and offset 0x14C reads 0x600.
- R11: A read of an undecoded offset returns 0. Any access to an undecoded offset raises `bad_access` for exactly the next cycle. Decoded offsets with no storage (0x064 and 0x118 to 0x124) read 0 without raising the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, loads the defaults |
| req_valid | input | 1 | Register access in this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 10 | Byte offset of the access |
| req_wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data for the current offset |
| bad_access | output | 1 | Pulse: previous access hit no register |
| evt_set | input | 13 | Event set pulses, bit i sets flag 19+i |
| rx_on_set | input | 1 | Engine found a free receive descriptor |
| rx_on_clr | input | 1 | Engine ran out of receive descriptors |
| irq | output | 13 | Per-source interrupt lines |
| tx_kick | output | 1 | Start pulse for the transmit engine |
| rx_kick | output | 1 | Start pulse for the receive engine |
| rx_active | output | 1 | Receive-active flag |
| mac_en | output | 1 | Control enable bit |
| rx_ctrl | output | 32 | Receive control word |
| station_addr | output | 48 | Station address, byte 0 in 47:40 |
| rx_ring | output | 32 | Receive ring base |
| tx_ring | output | 32 | Transmit ring base |
| max_rx_buf | output | 32 | Maximum receive buffer size |

## Verification
The properties assume the following about the inputs:
- Every input changes only between rising edges.
- `req_write` is meaningful only while `req_valid` is high.
- A set pulse and a clear-all write may coincide, which is why the clear property requires `evt_set` to be idle.

The stimulus drives every input on the falling edge and holds each access for one cycle. It raises engine pulses only in cycles that are chosen on purpose, including one cycle that deliberately overlaps a clear-write.

// File: rtl/mac_csr_pkg.sv
package mac_csr_pkg;
  localparam int ADDR_W  = 10;
  localparam int DATA_W  = 32;
  localparam int NUM_EVT = 13;
  localparam int EVT_LSB = 19;
  localparam int GRA_IDX = 28 - EVT_LSB;

  localparam logic [DATA_W-1:0] RCTL_DEF   = 32'h05EE_0001;
  localparam logic [DATA_W-1:0] RFIFO_DEF  = 32'h0000_0500;
  localparam logic [DATA_W-1:0] SPEED_KEEP = 32'h0000_00FE;
  localparam logic [DATA_W-1:0] RCTL_KEEP  = 32'h07FF_003F;
  localparam logic [DATA_W-1:0] RFIFO_KEEP = 32'h0000_03FC;
  localparam logic [DATA_W-1:0] RFIFO_SET  = 32'h0000_0400;
  localparam logic [DATA_W-1:0] MBUF_KEEP  = 32'h0000_07F0;

  typedef struct packed {
    logic evt, mask, rxtrig, txtrig, ctrl, mii, speed, stats, rctl, tctl;
    logic alo, ahi, opd, hash, wmark, fbound, rfifo, rring, tring, mbuf;
  } hit_t;

  // interrupt line -> event flag index (relative to EVT_LSB)
  function automatic int irq_src(input int line);
    case (line)
      0: return 8;   1: return 7;   2: return 0;   3: return 1;
      4: return 6;   5: return 5;   6: return 4;   7: return 2;
      8: return 12;  9: return 9;   10: return 3;  11: return 10;
      default: return 11;
    endcase
  endfunction
endpackage

// File: rtl/mac_csr_decode.sv
module mac_csr_decode
  import mac_csr_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  logic [AW-1:0] addr,
  output hit_t          hit,
  output logic          known
);
  always_comb begin
    hit = '0;
    case (addr)
      10'h004: hit.evt    = 1'b1;
      10'h008: hit.mask   = 1'b1;
      10'h010: hit.rxtrig = 1'b1;
      10'h014: hit.txtrig = 1'b1;
      10'h024: hit.ctrl   = 1'b1;
      10'h040: hit.mii    = 1'b1;
      10'h044: hit.speed  = 1'b1;
      10'h064: hit.stats  = 1'b1;
      10'h084: hit.rctl   = 1'b1;
      10'h0C4: hit.tctl   = 1'b1;
      10'h0E4: hit.alo    = 1'b1;
      10'h0E8: hit.ahi    = 1'b1;
      10'h0EC: hit.opd    = 1'b1;
      10'h118, 10'h11C, 10'h120, 10'h124: hit.hash = 1'b1;
      10'h144: hit.wmark  = 1'b1;
      10'h14C: hit.fbound = 1'b1;
      10'h150: hit.rfifo  = 1'b1;
      10'h180: hit.rring  = 1'b1;
      10'h184: hit.tring  = 1'b1;
      10'h188: hit.mbuf   = 1'b1;
      default: ;
    endcase
  end
  assign known = |hit;
endmodule

// File: rtl/mac_csr_cfg.sv
module mac_csr_cfg
  import mac_csr_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic          soft_rst,
  input  hit_t          hit,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic [DW-1:0] rx_ctrl,
  output logic [47:0]   station_addr,
  output logic [DW-1:0] rx_ring,
  output logic [DW-1:0] tx_ring,
  output logic [DW-1:0] max_rx_buf
);
  localparam logic [DW-1:0] ALIGN = ~{{(DW-2){1'b0}}, 2'b11};

  logic [DW-1:0] mii_q, speed_q, rctl_q, tctl_q, alo_q, rfifo_q;
  logic [DW-1:0] rring_q, tring_q, mbuf_q;
  logic [15:0]   ahi_q;
  logic [1:0]    wmark_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mii_q <= '0; speed_q <= '0; rctl_q <= RCTL_DEF; tctl_q <= '0;
      alo_q <= '0; ahi_q <= '0; wmark_q <= '0; rfifo_q <= RFIFO_DEF;
      rring_q <= '0; tring_q <= '0; mbuf_q <= '0;
    end else if (soft_rst) begin
      speed_q <= '0; rctl_q <= RCTL_DEF; tctl_q <= '0;
      wmark_q <= '0; rfifo_q <= RFIFO_DEF;
    end else if (we) begin
      if (hit.mii)   mii_q   <= wdata;
      if (hit.speed) speed_q <= wdata & SPEED_KEEP;
      if (hit.rctl)  rctl_q  <= wdata & RCTL_KEEP;
      if (hit.tctl)  tctl_q  <= wdata;
      if (hit.alo)   alo_q   <= wdata;
      if (hit.ahi)   ahi_q   <= wdata[DW-1 -: 16];
      if (hit.wmark) wmark_q <= wdata[1:0];
      if (hit.rfifo) rfifo_q <= (wdata & RFIFO_KEEP) | RFIFO_SET;
      if (hit.rring) rring_q <= wdata & ALIGN;
      if (hit.tring) tring_q <= wdata & ALIGN;
      if (hit.mbuf)  mbuf_q  <= wdata & MBUF_KEEP;
    end
  end

  always_comb begin
    rdata = '0;
    if (hit.mii)   rdata = mii_q;
    if (hit.speed) rdata = speed_q;
    if (hit.rctl)  rdata = rctl_q;
    if (hit.tctl)  rdata = tctl_q;
    if (hit.alo)   rdata = alo_q;
    if (hit.ahi)   rdata = {ahi_q, 16'h8808};
    if (hit.wmark) rdata = {{(DW-2){1'b0}}, wmark_q};
    if (hit.rfifo) rdata = rfifo_q;
    if (hit.rring) rdata = rring_q;
    if (hit.tring) rdata = tring_q;
    if (hit.mbuf)  rdata = mbuf_q;
  end

  assign rx_ctrl      = rctl_q;
  assign station_addr = {alo_q, ahi_q};
  assign rx_ring      = rring_q;
  assign tx_ring      = tring_q;
  assign max_rx_buf   = mbuf_q;
endmodule

// File: rtl/mac_csr_events.sv
module mac_csr_events
  import mac_csr_pkg::*;
#(
  parameter int N   = NUM_EVT,
  parameter int LSB = EVT_LSB,
  parameter int DW  = DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          soft_rst,
  input  logic          clr_we,
  input  logic          mask_we,
  input  logic [DW-1:0] wdata,
  input  logic [N-1:0]  set_vec,
  output logic [N-1:0]  evt,
  output logic [DW-1:0] mask,
  output logic [N-1:0]  irq
);
  logic [N-1:0] kept;

  always_comb begin
    if (soft_rst)    kept = '0;
    else if (clr_we) kept = evt & ~wdata[LSB +: N];
    else             kept = evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt  <= '0;
      mask <= '0;
    end else begin
      evt <= kept | set_vec;               // a set beats a clear
      if (soft_rst)     mask <= '0;
      else if (mask_we) mask <= wdata;
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_line
    localparam int SRC = irq_src(g);
    assign irq[g] = evt[SRC] & mask[LSB + SRC];
  end
endmodule

// File: rtl/mac_csr_irq.sv
module mac_csr_irq
  import mac_csr_pkg::*;
#(
  parameter int AW   = ADDR_W,
  parameter int DW   = DATA_W,
  parameter int NIRQ = NUM_EVT
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic            req_write,
  input  logic [AW-1:0]   req_addr,
  input  logic [DW-1:0]   req_wdata,
  output logic [DW-1:0]   rd_data,
  output logic            bad_access,
  input  logic [NIRQ-1:0] evt_set,
  input  logic            rx_on_set,
  input  logic            rx_on_clr,
  output logic [NIRQ-1:0] irq,
  output logic            tx_kick,
  output logic            rx_kick,
  output logic            rx_active,
  output logic            mac_en,
  output logic [DW-1:0]   rx_ctrl,
  output logic [47:0]     station_addr,
  output logic [DW-1:0]   rx_ring,
  output logic [DW-1:0]   tx_ring,
  output logic [DW-1:0]   max_rx_buf
);
  hit_t            hit;
  logic            known, wr, soft_rst, gra, ctrl_off;
  logic [DW-1:0]   ctrl_q, cfg_rdata, mask;
  logic [NIRQ-1:0] evt, set_vec;

  mac_csr_decode #(.AW(AW)) u_dec (.addr(req_addr), .hit(hit), .known(known));

  assign wr       = req_valid & req_write;
  assign soft_rst = wr & hit.ctrl & req_wdata[0];
  assign ctrl_off = wr & hit.ctrl & (req_wdata[0] | ~req_wdata[1]);
  assign gra      = wr & hit.tctl & req_wdata[0];
  assign set_vec  = evt_set | (NIRQ'(gra) << GRA_IDX);

  mac_csr_cfg #(.DW(DW)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(wr), .soft_rst(soft_rst), .hit(hit),
    .wdata(req_wdata), .rdata(cfg_rdata), .rx_ctrl(rx_ctrl),
    .station_addr(station_addr), .rx_ring(rx_ring), .tx_ring(tx_ring),
    .max_rx_buf(max_rx_buf)
  );

  mac_csr_events #(.N(NIRQ), .LSB(EVT_LSB), .DW(DW)) u_evt (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
    .clr_we(wr & hit.evt), .mask_we(wr & hit.mask), .wdata(req_wdata),
    .set_vec(set_vec), .evt(evt), .mask(mask), .irq(irq)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q     <= '0;
      rx_active  <= 1'b0;
      tx_kick    <= 1'b0;
      rx_kick    <= 1'b0;
      bad_access <= 1'b0;
    end else begin
      if (wr && hit.ctrl) ctrl_q <= req_wdata[0] ? '0 : req_wdata;
      if (ctrl_off)                    rx_active <= 1'b0;
      else if (rx_on_clr)              rx_active <= 1'b0;
      else if (rx_on_set && ctrl_q[1]) rx_active <= 1'b1;
      tx_kick    <= wr & hit.txtrig & ctrl_q[1];
      rx_kick    <= wr & hit.rxtrig & ctrl_q[1] & ~rx_active;
      bad_access <= req_valid & ~known;
    end
  end

  assign mac_en = ctrl_q[1];

  always_comb begin
    rd_data = cfg_rdata;
    if (hit.evt)    rd_data = {evt, {EVT_LSB{1'b0}}};
    if (hit.mask)   rd_data = mask;
    if (hit.rxtrig) rd_data = DW'(rx_active) << 24;
    if (hit.ctrl)   rd_data = ctrl_q;
    if (hit.opd)    rd_data = DW'(32'h0001_0000);
    if (hit.fbound) rd_data = DW'(32'h0000_0600);
  end
endmodule

// File: rtl/mac_csr_chk.sv
module mac_csr_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_write,
  input logic [9:0]  req_addr,
  input logic [31:0] req_wdata,
  input logic [12:0] evt_set,
  input logic [12:0] irq,
  input logic        tx_kick,
  input logic        rx_kick,
  input logic        rx_active,
  input logic        mac_en,
  input logic        bad_access,
  input logic [31:0] rx_ctrl
);
  assert_clear_all_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_addr == 10'h004 && req_wdata == 32'hFFFF_FFFF
     && evt_set == 13'd0) |=> (irq == 13'd0));

  assert_zero_mask_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_addr == 10'h008 && req_wdata == 32'd0)
    |=> (irq == 13'd0));

  assert_soft_default_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_addr == 10'h024 && req_wdata[0])
    |=> (rx_ctrl == 32'h05EE_0001 && !mac_en && !rx_active));

  assert_rx_needs_en_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_active |-> mac_en);

  assert_rx_kick_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rx_kick |-> $past(req_valid && req_write && req_addr == 10'h010
                      && mac_en && !rx_active));

  assert_tx_kick_R7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_kick |-> $past(req_valid && req_write && req_addr == 10'h014 && mac_en));

  assert_bad_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    bad_access |-> $past(req_valid));
endmodule

bind mac_csr_irq mac_csr_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .req_addr(req_addr), .req_wdata(req_wdata), .evt_set(evt_set), .irq(irq),
  .tx_kick(tx_kick), .rx_kick(rx_kick), .rx_active(rx_active),
  .mac_en(mac_en), .bad_access(bad_access), .rx_ctrl(rx_ctrl)
);

// File: tb/sim_mac_csr_irq.sv
`timescale 1ns/1ps
module sim_mac_csr_irq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [9:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [31:0] rd_data;
  logic        bad_access;
  logic [12:0] evt_set = '0;
  logic        rx_on_set = 1'b0, rx_on_clr = 1'b0;
  logic [12:0] irq;
  logic        tx_kick, rx_kick, rx_active, mac_en;
  logic [31:0] rx_ctrl, rx_ring, tx_ring, max_rx_buf;
  logic [47:0] station_addr;

  int errors = 0;
  int checks = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  event        probe;

  always #2 clk = ~clk;

  mac_csr_irq u0 (.*);

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: compares each read against the queued expectation
  initial forever begin
    @(probe);
    chk(tag_q.pop_front(), {32'd0, rd_data}, {32'd0, exp_q.pop_front()});
  end

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd(input logic [9:0] a, input logic [31:0] e, input string t);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    exp_q.push_back(e); tag_q.push_back(t);
    #1 ->probe;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // reset state
    rd(10'h084, 32'h05EE_0001, "R4 reset rx control");
    rd(10'h150, 32'h0000_0500, "R4 reset rx fifo start");
    rd(10'h004, 32'h0, "R1 reset events");
    rd(10'h024, 32'h0, "R4 reset control");
    rd(10'h0E8, 32'h0000_8808, "R10 upper address low half");
    rd(10'h0EC, 32'h0001_0000, "R10 constant 0x0EC");
    rd(10'h14C, 32'h0000_0600, "R10 constant 0x14C");
    rd(10'h014, 32'h0, "R7 tx trigger reads zero");
    chk("R5 rx_active after reset", {63'd0, rx_active}, 64'd0);

    // R8 write masks
    wr(10'h044, 32'hFFFF_FFFF); rd(10'h044, 32'h0000_00FE, "R8 speed mask");
    wr(10'h084, 32'hFFFF_FFFF); rd(10'h084, 32'h07FF_003F, "R8 rx control mask");
    wr(10'h144, 32'hFFFF_FFFF); rd(10'h144, 32'h0000_0003, "R8 watermark mask");
    wr(10'h150, 32'hFFFF_FFFF); rd(10'h150, 32'h0000_07FC, "R8 rx fifo start");
    wr(10'h150, 32'h0); rd(10'h150, 32'h0000_0400, "R8 rx fifo forced bit");
    wr(10'h180, 32'h0000_1237); rd(10'h180, 32'h0000_1234, "R8 rx ring align");
    wr(10'h184, 32'hFFFF_FFFF); rd(10'h184, 32'hFFFF_FFFC, "R8 tx ring align");
    wr(10'h188, 32'h0000_FFFF); rd(10'h188, 32'h0000_07F0, "R8 max buffer mask");
    chk("R8 rx_ring port", {32'd0, rx_ring}, 64'h1234);

    // R10 station address
    wr(10'h0E4, 32'h1122_3344);
    wr(10'h0E8, 32'h5566_ABCD);
    rd(10'h0E8, 32'h5566_8808, "R10 upper address readback");
    rd(10'h0E4, 32'h1122_3344, "R10 lower address readback");
    chk("R10 station_addr port", {16'd0, station_addr}, 64'h1122_3344_5566);

    // R3 mask, R1 set input, R2 mapping
    wr(10'h008, 32'hFFFF_FFFF); rd(10'h008, 32'hFFFF_FFFF, "R3 mask readback");
    @(negedge clk); evt_set = 13'h1FFF;
    @(negedge clk); evt_set = '0;
    rd(10'h004, 32'hFFF8_0000, "R1 set pulses");
    chk("R2 all lines", {51'd0, irq}, 64'h1FFF);
    wr(10'h008, 32'h0800_0000);
    chk("R2 bit27 -> line 0", {51'd0, irq}, 64'h0001);
    wr(10'h008, 32'h8000_0000);
    chk("R2 bit31 -> line 8", {51'd0, irq}, 64'h0100);
    wr(10'h008, 32'h0008_0000);
    chk("R2 bit19 -> line 2", {51'd0, irq}, 64'h0004);
    wr(10'h008, 32'h4000_0000);
    chk("R2 bit30 -> line 12", {51'd0, irq}, 64'h1000);

    // R1 write-one-to-clear and set priority
    wr(10'h004, 32'h8000_0000);
    rd(10'h004, 32'h7FF8_0000, "R1 clear one flag");
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 10'h004;
    req_wdata = 32'h4000_0000; evt_set = 13'h0800;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0; evt_set = '0;
    rd(10'h004, 32'h7FF8_0000, "R1 set beats clear");
    wr(10'h004, 32'hFFFF_FFFF);
    rd(10'h004, 32'h0, "R1 clear all");

    // R9 graceful stop
    wr(10'h0C4, 32'h0000_0004);
    rd(10'h004, 32'h0, "R9 no stop without bit 0");
    wr(10'h0C4, 32'h0000_0001);
    rd(10'h004, 32'h1000_0000, "R9 stop event raised");

    // R7 / R6 / R5 kicks and receive flag
    wr(10'h014, 32'h0);
    chk("R7 no tx kick while disabled", {63'd0, tx_kick}, 64'd0);
    wr(10'h010, 32'h0);
    chk("R6 no rx kick while disabled", {63'd0, rx_kick}, 64'd0);
    wr(10'h024, 32'h0000_0002);
    wr(10'h014, 32'h0);
    chk("R7 tx kick", {63'd0, tx_kick}, 64'd1);
    @(negedge clk);
    chk("R7 tx kick one cycle", {63'd0, tx_kick}, 64'd0);
    wr(10'h010, 32'h0);
    chk("R6 rx kick", {63'd0, rx_kick}, 64'd1);
    @(negedge clk);
    chk("R6 rx kick one cycle", {63'd0, rx_kick}, 64'd0);
    @(negedge clk); rx_on_set = 1'b1;
    @(negedge clk); rx_on_set = 1'b0;
    rd(10'h010, 32'h0100_0000, "R5 receive active bit 24");
    wr(10'h010, 32'h0);
    chk("R6 no rx kick while active", {63'd0, rx_kick}, 64'd0);
    @(negedge clk); rx_on_clr = 1'b1;
    @(negedge clk); rx_on_clr = 1'b0;
    chk("R5 engine clears active", {63'd0, rx_active}, 64'd0);
    @(negedge clk); rx_on_set = 1'b1;
    @(negedge clk); rx_on_set = 1'b0;
    wr(10'h024, 32'h0);
    rd(10'h010, 32'h0, "R5 disable clears active");
    @(negedge clk); rx_on_set = 1'b1;
    @(negedge clk); rx_on_set = 1'b0;
    chk("R5 no set while disabled", {63'd0, rx_active}, 64'd0);

    // R4 soft reset
    wr(10'h008, 32'h0000_FFFF);
    wr(10'h044, 32'h0000_0010);
    wr(10'h024, 32'h0000_0003);
    rd(10'h024, 32'h0, "R4 control after soft reset");
    rd(10'h084, 32'h05EE_0001, "R4 rx control default");
    rd(10'h044, 32'h0, "R4 speed cleared");
    rd(10'h0C4, 32'h0, "R4 tx control cleared");
    rd(10'h008, 32'h0, "R4 mask cleared");
    rd(10'h004, 32'h0, "R4 events cleared");
    rd(10'h144, 32'h0, "R4 watermark cleared");
    rd(10'h150, 32'h0000_0500, "R4 rx fifo default");
    rd(10'h180, 32'h0000_1234, "R4 ring base kept");

    // R11 undecoded access
    rd(10'h3FC, 32'h0, "R11 undecoded reads zero");
    chk("R11 bad access flagged", {63'd0, bad_access}, 64'd1);
    @(negedge clk);
    chk("R11 bad access one cycle", {63'd0, bad_access}, 64'd0);
    rd(10'h118, 32'h0, "R11 filter word reads zero");
    chk("R11 decoded no flag", {63'd0, bad_access}, 64'd0);
    wr(10'h2A0, 32'hDEAD_BEEF);
    chk("R11 bad write flagged", {63'd0, bad_access}, 64'd1);

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule